// File: doc/BRIEF.md
# Blanked Bidirectional Overcurrent Monitor

This block guards the low-side switch of a half-bridge power stage. Two comparator flags arrive from the analog front end. One says the switch node sits above the positive trip level. The other says it sits below the negative trip level. The block looks at these flags only while the low-side enable is high. It ignores them for a fixed blanking window after each low-side turn-on, because the switching edge rings. A fault of either polarity pulls an active-low fault line down, and that low level is stretched to a guaranteed minimum width so that a slow reader cannot miss it.

The fault line is modelled as an open-drain driver. `fault_oe` high means the pin is pulled low. `fault_n` is the level the pin then reads. While power-good is low, the output is released and all internal state is cleared. The comparator flags are asynchronous and pass through a two-flop synchronizer. The low-side enable comes from the same clock domain. With the intended 200 MHz clock, the default 40-cycle blanking is 200 ns and the default 20-cycle stretch is 100 ns.

Top module: `ocmon_top`

## Requirements
- R1: While `lo_en` is low, the comparator flags never cause a fault. `fault_oe` can rise only after a cycle in which `lo_en` was high.
- R2: Either flag, `flag_hi` or `flag_lo`, is enough to raise a fault once sensing is qualified (logical OR of the two polarities).
- R3: Sensing is blanked for BLANK_CYC (default 40) cycles after `lo_en` rises. With a flag already steady high, `fault_oe` rises at the 41st rising clock edge, counting from the first edge that samples `lo_en` high.
- R4: A low-side on-time of BLANK_CYC cycles or fewer produces no fault, even with a flag held high for that whole time.
- R5: The blanking count clears whenever `lo_en` is low. Each new on-interval gets the full blanking window again, even after an off-time of a single cycle.
- R6: The output is active low. `fault_oe`=1 together with `fault_n`=0 signals a fault. `fault_oe`=0 together with `fault_n`=1 is the released state, and this is also the state right after reset.
- R7: A qualified fault holds `fault_oe` high for as long as it persists, plus MIN_CYC-1 (default 19) more cycles. A one-cycle fault gives a low pulse exactly MIN_CYC cycles wide. A new fault during the stretch restarts the stretch.
- R8: While `pwr_good` is low, `fault_oe` is 0 from the next clock edge onward and all counters and synchronizers are cleared. After `pwr_good` returns, a fresh blanking window of BLANK_CYC cycles applies, even if `lo_en` stayed high throughout.
- R9: With sensing qualified, `fault_oe` rises at the third rising clock edge after a flag rises (two synchronizer stages plus the output register).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supplies valid; low releases the output and clears all state |
| lo_en | input | 1 | Low-side switch enable, synchronous to clk |
| flag_hi | input | 1 | Asynchronous flag: node above the positive trip level |
| flag_lo | input | 1 | Asynchronous flag: node below the negative trip level |
| fault_oe | output | 1 | Open-drain enable; 1 pulls the fault line low |
| fault_n | output | 1 | Level of the fault line: 0 during a fault, 1 when released |

## Verification
A flag change reaches `fault_oe` three edges later. A rising `lo_en` with a flag already high yields a fault 41 edges later. A `pwr_good` drop releases the output at the very next edge. The fault stays asserted for 19 edges after the last qualified cycle. The bench drives all inputs on the falling edge and samples both outputs on the next falling edge. Its reference model advances once per rising edge, using the synchronizer depth, blanking count and stretch length written as plain integers and history counters. Latency, blanking and pulse-width scenarios additionally count falling edges between stimulus and response, and compare that count against the numbers stated in the requirements.

// File: rtl/ocm_pkg.sv
package ocm_pkg;
    localparam int unsigned DEF_BLANK_CYC = 40;
    localparam int unsigned DEF_MIN_CYC   = 20;
    localparam int unsigned SYNC_STAGES   = 2;
    localparam int unsigned NUM_FLAGS     = 2;
endpackage

// File: rtl/ocm_sync.sv
module ocm_sync #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.s1 = '0;
            st_d.s2 = '0;
        end else begin
            st_d.s1 = d;
            st_d.s2 = st_q.s1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.s2;
endmodule

// File: rtl/ocm_blank.sv
module ocm_blank #(
    parameter int unsigned BLANK_CYC = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic lo_en,
    output logic armed
);
    localparam int unsigned CW = $clog2(BLANK_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(BLANK_CYC);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } blank_t;

    blank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pwr_good || !lo_en) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed = pwr_good && lo_en && (st_q.cnt == LIMIT);

    // R3
    blank_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lo_en) |-> !armed);

    // R5
    blank_needs_prior_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> $past(lo_en));
endmodule

// File: rtl/ocm_stretch.sv
module ocm_stretch #(
    parameter int unsigned MIN_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic trig,
    output logic pull
);
    localparam int unsigned HW = (MIN_CYC > 2) ? $clog2(MIN_CYC) : 1;
    localparam logic [HW-1:0] RELOAD = HW'(MIN_CYC - 1);

    typedef struct packed {
        logic [HW-1:0] hold;
        logic          pull;
    } str_t;

    str_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!pwr_good) begin
            st_d.hold = '0;
            st_d.pull = 1'b0;
        end else if (trig) begin
            st_d.hold = RELOAD;
            st_d.pull = 1'b1;
        end else if (st_q.hold != '0) begin
            st_d.hold = st_q.hold - 1'b1;
            st_d.pull = 1'b1;
        end else begin
            st_d.pull = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pull = st_q.pull;

    localparam int unsigned RW = $clog2(MIN_CYC + 1);
    logic [RW-1:0] run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     run_q <= '0;
        else if (!st_q.pull)            run_q <= '0;
        else if (run_q != RW'(MIN_CYC)) run_q <= run_q + 1'b1;
    end

    // R7
    min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.pull && $past(st_q.pull) && $past(pwr_good)) |-> (run_q == RW'(MIN_CYC)));
endmodule

// File: rtl/ocmon_top.sv
module ocmon_top
    import ocm_pkg::*;
#(
    parameter int unsigned BLANK_CYC = DEF_BLANK_CYC,
    parameter int unsigned MIN_CYC   = DEF_MIN_CYC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic lo_en,
    input  logic flag_hi,
    input  logic flag_lo,
    output logic fault_oe,
    output logic fault_n
);
    logic [NUM_FLAGS-1:0] flags_async;
    logic [NUM_FLAGS-1:0] flags_sync;
    logic                 armed;
    logic                 fault_raw;
    logic                 pull;

    assign flags_async = {flag_lo, flag_hi};

    ocm_sync #(.W(NUM_FLAGS)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!pwr_good),
        .d     (flags_async),
        .q     (flags_sync)
    );

    ocm_blank #(.BLANK_CYC(BLANK_CYC)) i_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .lo_en    (lo_en),
        .armed    (armed)
    );

    assign fault_raw = armed && (|flags_sync);

    ocm_stretch #(.MIN_CYC(MIN_CYC)) i_stretch (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .trig     (fault_raw),
        .pull     (pull)
    );

    assign fault_oe = pull;
    assign fault_n  = !pull;

    // R1
    rise_needs_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_oe) |-> $past(lo_en));

    // R2
    either_flag_trips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (|flags_sync)) |=> fault_oe);

    // R8
    pg_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !fault_oe);

    // R6
    polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_n != fault_oe);
endmodule

// File: tb/test_ocmon_top.sv
module test_ocmon_top;
    localparam int BLANK = 40;
    localparam int MINW  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic lo_en = 1'b0;
    logic flag_hi = 1'b0;
    logic flag_lo = 1'b0;
    logic fault_oe;
    logic fault_n;

    always #4 clk = ~clk;

    ocmon_top i_ocmon_top (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .lo_en(lo_en),
        .flag_hi(flag_hi), .flag_lo(flag_lo), .fault_oe(fault_oe), .fault_n(fault_n)
    );

    int errors = 0;
    int checks = 0;
    string cur_req = "R6";

    // behavioural reference, advanced once per rising edge
    int m_q1 = 0, m_q2 = 0, m_run = 0, m_last = -100000, m_n = 0;
    bit m_exp = 1'b0;

    always @(posedge clk) begin
        if (!rst_n || !pwr_good) begin
            m_q1 = 0; m_q2 = 0; m_run = 0; m_last = -100000;
        end else begin
            if (lo_en && m_run >= BLANK && m_q2 != 0) m_last = m_n;
            m_q2 = m_q1;
            m_q1 = (flag_hi || flag_lo) ? 1 : 0;
            m_run = lo_en ? m_run + 1 : 0;
        end
        m_exp = rst_n && pwr_good && ((m_n - m_last) < MINW);
        m_n++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(fault_oe == m_exp, cur_req, int'(fault_oe), int'(m_exp));
            check(fault_n == !m_exp, "R6", int'(fault_n), int'(!m_exp));
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", wd, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // negedges until fault_oe is seen high (bounded)
    task automatic edges_to_rise(output int n);
        n = 0;
        while (n < 500) begin
            @(negedge clk);
            n++;
            if (fault_oe) break;
        end
    endtask

    // width of the current or next high phase of fault_oe
    task automatic measure_width(output int w);
        int g = 0;
        w = 0;
        while (!fault_oe && g < 500) begin @(negedge clk); g++; end
        while (fault_oe && w < 1000) begin @(negedge clk); w++; end
    endtask

    initial begin
        int n;
        int w;
        int seen;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R6 reset state
        check(fault_oe == 1'b0 && fault_n == 1'b1, "R6", int'(fault_oe), 0);
        pwr_good = 1'b1;

        // R1: flags high with low side off
        cur_req = "R1";
        flag_hi = 1'b1; flag_lo = 1'b1;
        seen = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (fault_oe) seen++; end
        check(seen == 0, "R1", seen, 0);
        flag_lo = 1'b0;

        // R3: blanking with flag already steady
        cur_req = "R3";
        lo_en = 1'b1;
        edges_to_rise(n);
        check(n == BLANK + 1, "R3", n, BLANK + 1);
        step(5);
        flag_hi = 1'b0;
        step(30);
        lo_en = 1'b0;
        step(5);

        // R4: on-time of exactly BLANK cycles
        cur_req = "R4";
        flag_hi = 1'b1;
        step(3);
        lo_en = 1'b1;
        seen = 0;
        for (int i = 0; i < BLANK; i++) begin @(negedge clk); if (fault_oe) seen++; end
        lo_en = 1'b0;
        for (int i = 0; i < 5; i++) begin @(negedge clk); if (fault_oe) seen++; end
        check(seen == 0, "R4", seen, 0);
        // shorter on-time
        lo_en = 1'b1;
        step(25);
        lo_en = 1'b0;
        step(3);
        check(fault_oe == 1'b0, "R4", int'(fault_oe), 0);

        // R5: one-cycle off-time restarts blanking
        cur_req = "R5";
        lo_en = 1'b1;
        step(30);
        lo_en = 1'b0;
        step(1);
        lo_en = 1'b1;
        seen = 0;
        for (int i = 0; i < 35; i++) begin @(negedge clk); if (fault_oe) seen++; end
        check(seen == 0, "R5", seen, 0);
        flag_hi = 1'b0;
        step(30);

        // R2 and R9: negative-polarity flag, latency
        cur_req = "R2";
        flag_lo = 1'b1;
        edges_to_rise(n);
        check(n == 3, "R9", n, 3);
        check(fault_oe == 1'b1, "R2", int'(fault_oe), 1);
        flag_lo = 1'b0;
        step(30);
        flag_hi = 1'b1;
        edges_to_rise(n);
        check(n == 3, "R2", n, 3);
        flag_hi = 1'b0;
        step(30);

        // R7: single-cycle fault
        cur_req = "R7";
        flag_hi = 1'b1;
        step(1);
        flag_hi = 1'b0;
        measure_width(w);
        check(w == MINW, "R7", w, MINW);
        step(5);
        // persistent fault of 50 cycles
        flag_lo = 1'b1;
        step(1);
        flag_lo = 1'b0 ? 1'b0 : 1'b1;
        step(49);
        flag_lo = 1'b0;
        step(5);
        check(fault_oe == 1'b1, "R7", int'(fault_oe), 1);
        step(40);
        // retrigger within stretch
        flag_hi = 1'b1; step(1); flag_hi = 1'b0;
        step(9);
        flag_hi = 1'b1; step(1); flag_hi = 1'b0;
        measure_width(w);
        check(w == MINW + 10 - 8, "R7", w, MINW + 2);
        step(30);

        // R8: power-good drop during a fault, then fresh blanking
        cur_req = "R8";
        flag_hi = 1'b1;
        step(10);
        check(fault_oe == 1'b1, "R8", int'(fault_oe), 1);
        pwr_good = 1'b0;
        step(1);
        check(fault_oe == 1'b0, "R8", int'(fault_oe), 0);
        step(20);
        check(fault_oe == 1'b0, "R8", int'(fault_oe), 0);
        pwr_good = 1'b1;
        edges_to_rise(n);
        check(n == BLANK + 1, "R8", n, BLANK + 1);
        flag_hi = 1'b0;
        lo_en = 1'b0;
        step(30);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule